// File: doc/BRIEF.md
# Dual-Rank Serial Control Register

This block is a serial slave that receives an 8-bit control word over a serial clock and data pin and presents it on a parallel control bus through two stages of holding registers. Bits enter a shift register on rising serial clock edges, least significant bit first. While the active-low select is low, the first holding stage tracks the shift register, and it keeps its value from the moment select rises. The second holding stage, which drives the control bus, tracks the first stage while the active-low load pin is low and keeps its value once load rises. Because the two stages are separate, a long chain of these slaves can be shifted one after another and then all updated together by a single load pulse.

Each bit also leaves the shift register on a serial data out pin, which changes on falling serial clock edges. That pin feeds the data input of the next slave in a chain. The block runs on a fast system clock. All serial pins go through two-flop synchronizers, and their edges are detected in that domain. The system clock must run at least four times faster than the serial clock. An active-low reset returns both holding stages to a parameterised default value and clears the shift register.

Top module: `dual_rank_sreg`

## Requirements
- R1: The shift register takes one bit from the data input on each rising serial clock edge, and a full word takes 8 such edges.
- R2: Words arrive least significant bit first, so the first bit shifted in of a word ends up on control bit 0.
- R3: Serial data out changes only after a falling serial clock edge, and after the falling edge that follows the Nth rising edge it shows the bit sampled on rising edge N-8.
- R4: While select is high the shift register keeps shifting and driving serial data out, and the first stage does not change.
- R5: While select is low the first stage follows the shift register, and it holds its value from the rising edge of select.
- R6: While load is low the control bus follows the first stage. It holds from the rising edge of load, and it does not change while load stays high.
- R7: A load pulse updates the control bus with the serial clock idle.
- R8: An active-low reset sets the control bus and first stage to the RESET_VAL parameter, clears the shift register, and drives serial data out to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| clr_n | input | 1 | Active-low reset to defaults |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low select, gates first-stage capture |
| ld_n | input | 1 | Active-low load, gates second-stage update |
| sdo | output | 1 | Serial data out for chaining |
| ctrl | output | WIDTH | Parallel control bus (second stage) |

## Verification
The bench follows the serial output bit by bit against a record of every bit sent. A delay of 7 or 9 cycles, or an update on the wrong edge, therefore shows up at once as a shifted stream. It shifts a word with select high and then loads. A design that leaks into the first stage would put that word on the bus. It also shifts a second word after select has risen. A design that only holds while the serial clock is idle would load the later word. It shifts words while load is held low and then while load is high, which catches a second stage that ignores load or that is never transparent. A reset in the middle of activity must bring back the non-zero default and a serial output of all zeros. Stale shift contents would appear on the output as old bits.

// File: rtl/dual_rank_sreg.sv
module dual_rank_sreg #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             cs_n,
  input  logic             ld_n,
  output logic             sdo,
  output logic [WIDTH-1:0] ctrl
);

  logic [2:0]       sclk_p;
  logic [1:0]       sdi_p, cs_p, ld_p;
  logic             sclk_rise, sclk_fall, cs_hi, ld_hi;
  logic [WIDTH-1:0] sr, rank1, rank2;
  logic             out_bit;

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) begin
      sclk_p <= '0;
      sdi_p  <= '0;
      cs_p   <= '1;
      ld_p   <= '1;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      sdi_p  <= {sdi_p[0], sdi};
      cs_p   <= {cs_p[0], cs_n};
      ld_p   <= {ld_p[0], ld_n};
    end

  assign sclk_rise = sclk_p[1] & ~sclk_p[2];
  assign sclk_fall = ~sclk_p[1] & sclk_p[2];
  assign cs_hi     = cs_p[1];
  assign ld_hi     = ld_p[1];

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) begin
      sr      <= '0;
      out_bit <= 1'b0;
      sdo     <= 1'b0;
    end else begin
      if (sclk_rise) begin
        sr      <= {sdi_p[1], sr[WIDTH-1:1]};
        out_bit <= sr[0];
      end
      if (sclk_fall) sdo <= out_bit;
    end

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) begin
      rank1 <= RESET_VAL;
      rank2 <= RESET_VAL;
    end else begin
      if (!cs_hi) rank1 <= sr;
      if (!ld_hi) rank2 <= rank1;
    end

  assign ctrl = rank2;

  AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (!clr_n)
    !sclk_rise |=> $stable(sr)); // R1
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!clr_n)
    !sclk_fall |=> $stable(sdo)); // R3
  AST_RANK1_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    cs_hi |=> $stable(rank1)); // R4
  AST_RANK1_FOLLOW: assert property (@(posedge clk) disable iff (!clr_n)
    !cs_hi |=> rank1 == $past(sr)); // R5
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    ld_hi |=> $stable(ctrl)); // R6
  AST_CTRL_FOLLOW: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_hi |=> ctrl == $past(rank1)); // R6

endmodule

// File: tb/test_dual_rank_sreg.sv
module test_dual_rank_sreg;
  localparam logic [7:0] DEF = 8'hA5;
  localparam time HALF = 40ns;

  logic clk = 1'b0, clr_n = 1'b0, sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, ld_n = 1'b1;
  logic sdo;
  logic [7:0] ctrl;
  logic [63:0] sent = '0;
  int checks = 0, fails = 0;

  dual_rank_sreg #(.WIDTH(8), .RESET_VAL(DEF)) i_dual_rank_sreg (
    .clk(clk), .clr_n(clr_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .ld_n(ld_n),
    .sdo(sdo), .ctrl(ctrl));

  always #2.5ns clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    #(HALF); sclk = 1'b1;
    #(HALF); sclk = 1'b0;
    #(HALF);
    sent = {sent[62:0], b};
    check(sdo === sent[8], "R3 sdo delay", {7'd0, sdo}, {7'd0, sent[8]});
  endtask

  task automatic send_word(input logic [7:0] w, input bit sel);
    if (sel) begin cs_n = 1'b0; #(HALF); end
    for (int i = 0; i < 8; i++) send_bit(w[i]);
    cs_n = 1'b1; #(HALF);
  endtask

  task automatic pulse_load();
    ld_n = 1'b0; #(HALF); ld_n = 1'b1; #(HALF);
  endtask

  task automatic do_reset();
    clr_n = 1'b0; #(HALF); clr_n = 1'b1; sent = '0; #(HALF);
    check(ctrl === DEF, "R8 ctrl default", ctrl, DEF);
    check(sdo === 1'b0, "R8 sdo cleared", {7'd0, sdo}, 8'd0);
  endtask

  task automatic t_basic();
    send_word(8'h3C, 1'b1);
    check(ctrl === DEF, "R6 blocked while load high", ctrl, DEF);
    pulse_load();
    check(ctrl === 8'h3C, "R1 R7 word loaded", ctrl, 8'h3C);
    send_word(8'h01, 1'b1);
    pulse_load();
    check(ctrl === 8'h01, "R2 first bit on ctrl[0]", ctrl, 8'h01);
  endtask

  task automatic t_deselected();
    send_word(8'h5A, 1'b0);
    pulse_load();
    check(ctrl === 8'h01, "R4 rank1 unchanged with select high", ctrl, 8'h01);
  endtask

  task automatic t_cs_hold();
    send_word(8'hC3, 1'b1);
    send_word(8'h96, 1'b0);
    pulse_load();
    check(ctrl === 8'hC3, "R5 hold from select rise", ctrl, 8'hC3);
  endtask

  task automatic t_transparent();
    ld_n = 1'b0; #(HALF);
    send_word(8'h7E, 1'b1);
    check(ctrl === 8'h7E, "R6 transparent with load low", ctrl, 8'h7E);
    ld_n = 1'b1; #(HALF);
    send_word(8'h11, 1'b1);
    check(ctrl === 8'h7E, "R6 hold after load rise", ctrl, 8'h7E);
    pulse_load();
    check(ctrl === 8'h11, "R7 load with sclk idle", ctrl, 8'h11);
  endtask

  task automatic t_reset_mid();
    cs_n = 1'b0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    cs_n = 1'b1;
    do_reset();
    send_word(8'h00, 1'b0);
    pulse_load();
    check(ctrl === DEF, "R8 default kept after reset", ctrl, DEF);
  endtask

  initial begin
    #(100ns);
    clr_n = 1'b1; #(HALF);
    check(ctrl === DEF, "R8 reset state", ctrl, DEF);
    check(sdo === 1'b0, "R8 reset sdo", {7'd0, sdo}, 8'd0);
    t_basic();
    t_deselected();
    t_cs_hold();
    t_transparent();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(1ms);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule